// File: doc/BRIEF.md
# SCL Phase Timer with Bus Timeout

This block times the phases of the clock line for an I2C controller. A small up-counter is reloaded on every SCL transition with a start value picked by a 2-bit rate code. The start value is the fixed mark (8) minus the minimum phase length, in machine cycles, for that code. One fixed comparison against the mark therefore tells the controller that the minimum high or low time has passed, whatever the code. The same minimum also governs start and stop setup. If the line is held and counting runs on until the counter wraps, a sticky timeout flag is raised. The controller uses that flag to drop its slave-enable and master-request state.

The counter advances on machine-cycle ticks, which arrive as an enable, not as a separate clock. A run input gates the timer. While run is low the count is forced to zero and held there. A one-cycle clear strobe removes the timeout flag. Choosing the rate code from the clock frequency is left to the surrounding logic. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `scl_phase_timer`

## Requirements
- R1: After reset the count is 0 and both `min_elapsed` and `timeout` are low.
- R2: With `run` high, an `scl_edge` pulse loads the count with 8 minus the minimum for `rate_code`. The minimums are 7 for code 0, 5 for code 1, 4 for code 2 and 3 for code 3. An edge takes priority over a tick in the same cycle.
- R3: `min_elapsed` is high exactly when the count is at least 8. After an edge it therefore rises after the code's minimum number of ticks and no sooner.
- R4: With `run` high and no edge, the count advances by one only on cycles where `tick` is high. Otherwise it holds.
- R5: With `run` low, the count is cleared to 0 and stays there, and ticks and edges have no effect. When `run` returns high without an edge, counting resumes from 0.
- R6: A tick at count 1023 (10-bit all ones) wraps the count to 0 and sets `timeout`. `min_elapsed` is low after the wrap.
- R7: `timeout` stays set until a `clr_ovf` strobe. SCL edges and `run` low do not clear it.
- R8: If a wrap and `clr_ovf` fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle enable |
| scl_edge | input | 1 | One-cycle pulse on any SCL transition |
| rate_code | input | 2 | Selects minimum phase count |
| run | input | 1 | Timer enable; low stops and clears count |
| clr_ovf | input | 1 | Strobe that clears the timeout flag |
| min_elapsed | output | 1 | Minimum SCL phase time has passed |
| timeout | output | 1 | Sticky bus-timeout flag |

## Verification
The bench builds the block with its default parameters. These are a 10-bit counter, a mark of 8 and minimums of 7, 5, 4 and 3. With these values a full run from preload to wrap takes about a thousand ticks. Each timeout case, including the collision between a wrap and a clear, can therefore be reached directly in a short run. The small minimums also let every rate code be checked one tick either side of its threshold.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;
  localparam int unsigned NUM_RATES = 4;
  typedef logic [1:0] rate_t;
  // per-cycle action of the phase counter
  typedef enum logic [1:0] {
    CNT_CLEAR,
    CNT_LOAD,
    CNT_STEP,
    CNT_HOLD
  } cnt_op_t;
endpackage

// File: rtl/scl_preload_sel.sv
module scl_preload_sel
  import scl_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned MARK   = 8,
  parameter int unsigned MIN_C0 = 7,
  parameter int unsigned MIN_C1 = 5,
  parameter int unsigned MIN_C2 = 4,
  parameter int unsigned MIN_C3 = 3
) (
  input  rate_t             code,
  output logic [CNT_W-1:0]  preload
);
  localparam int unsigned MINS [NUM_RATES] = '{MIN_C0, MIN_C1, MIN_C2, MIN_C3};

  logic [CNT_W-1:0] start_val [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_start
    // start so that reaching MARK equals MINS[g] ticks
    assign start_val[g] = CNT_W'(MARK - MINS[g]);
  end

  assign preload = start_val[code];
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter
  import scl_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_t          op,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case (op)
        CNT_CLEAR: count <= '0;
        CNT_LOAD:  count <= preload;
        CNT_STEP:  count <= count + 1'b1;
        default:   count <= count;
      endcase
    end
  end

  assign wrap = (op == CNT_STEP) && (&count);
endmodule

// File: rtl/scl_timeout_flag.sv
module scl_timeout_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;   // a new timeout beats a clear
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned MARK   = 8,
  parameter int unsigned MIN_C0 = 7,
  parameter int unsigned MIN_C1 = 5,
  parameter int unsigned MIN_C2 = 4,
  parameter int unsigned MIN_C3 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       scl_edge,
  input  logic [1:0] rate_code,
  input  logic       run,
  input  logic       clr_ovf,
  output logic       min_elapsed,
  output logic       timeout
);
  localparam logic [CNT_W-1:0] MARK_V = CNT_W'(MARK);

  cnt_op_t          op;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  always_comb begin
    if (!run)          op = CNT_CLEAR;
    else if (scl_edge) op = CNT_LOAD;
    else if (tick)     op = CNT_STEP;
    else               op = CNT_HOLD;
  end

  scl_preload_sel #(
    .CNT_W(CNT_W), .MARK(MARK),
    .MIN_C0(MIN_C0), .MIN_C1(MIN_C1), .MIN_C2(MIN_C2), .MIN_C3(MIN_C3)
  ) u_sel (
    .code    (rate_code),
    .preload (preload)
  );

  scl_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .preload (preload),
    .count   (cnt_q),
    .wrap    (wrap)
  );

  scl_timeout_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wrap),
    .clr   (clr_ovf),
    .flag  (timeout)
  );

  assign min_elapsed = (cnt_q >= MARK_V);
endmodule

// File: rtl/scl_phase_timer_chk.sv
module scl_phase_timer_chk #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned MARK  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             scl_edge,
  input logic             run,
  input logic             clr_ovf,
  input logic [CNT_W-1:0] cnt_q,
  input logic             min_elapsed,
  input logic             timeout
);
  // R4
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scl_edge && !tick) |=> $stable(cnt_q));

  // R5
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !min_elapsed);

  // R3
  mark_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scl_edge && tick && cnt_q == CNT_W'(MARK - 1)) |=> min_elapsed);

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scl_edge && tick && (&cnt_q)) |=> timeout && !min_elapsed);

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !clr_ovf) |=> timeout);
endmodule

bind scl_phase_timer scl_phase_timer_chk #(.CNT_W(CNT_W), .MARK(MARK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .scl_edge    (scl_edge),
  .run         (run),
  .clr_ovf     (clr_ovf),
  .cnt_q       (cnt_q),
  .min_elapsed (min_elapsed),
  .timeout     (timeout)
);

// File: tb/sim_scl_phase_timer.sv
`timescale 1ns/1ps
module sim_scl_phase_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, scl_edge = 1'b0, run = 1'b0, clr_ovf = 1'b0;
  logic [1:0] rate_code = 2'd0;
  logic min_elapsed, timeout;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scl_phase_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_edge(scl_edge),
    .rate_code(rate_code), .run(run), .clr_ovf(clr_ovf),
    .min_elapsed(min_elapsed), .timeout(timeout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock with given inputs; results readable 1 ns after the edge
  task automatic cyc(input logic t, input logic e, input logic c);
    tick = t; scl_edge = e; clr_ovf = c;
    @(posedge clk); #1;
    tick = 1'b0; scl_edge = 1'b0; clr_ovf = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic edge_code(input logic [1:0] code);
    rate_code = code;
    cyc(1'b0, 1'b1, 1'b0);
  endtask

  function automatic int min_of(input int code);
    case (code)
      0: return 7;
      1: return 5;
      2: return 4;
      default: return 3;
    endcase
  endfunction

  task automatic t_reset;
    chk("R1 min_elapsed", min_elapsed, 1'b0);
    chk("R1 timeout", timeout, 1'b0);
  endtask

  task automatic t_min_per_code;
    run = 1'b1;
    for (int c = 0; c < 4; c++) begin
      edge_code(2'(c));
      ticks(min_of(c) - 1);
      chk("R3 one tick short", min_elapsed, 1'b0);
      ticks(1);
      chk("R2 R3 at minimum", min_elapsed, 1'b1);
    end
  endtask

  task automatic t_edge_beats_tick;
    rate_code = 2'd1;
    cyc(1'b1, 1'b1, 1'b0);   // loads 3, not 4
    ticks(4);
    chk("R2 edge priority short", min_elapsed, 1'b0);
    ticks(1);
    chk("R2 edge priority reach", min_elapsed, 1'b1);
  endtask

  task automatic t_hold;
    edge_code(2'd2);           // count 4
    ticks(3);                  // 7
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b0);
    chk("R4 holds without tick", min_elapsed, 1'b0);
    ticks(1);
    chk("R4 advances on tick", min_elapsed, 1'b1);
  endtask

  task automatic t_stop;
    edge_code(2'd0);
    ticks(7);
    chk("R5 pre-stop elapsed", min_elapsed, 1'b1);
    run = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R5 stop clears", min_elapsed, 1'b0);
    ticks(20);
    rate_code = 2'd3;
    cyc(1'b1, 1'b1, 1'b0);
    chk("R5 ignored while stopped", min_elapsed, 1'b0);
    chk("R5 no timeout while stopped", timeout, 1'b0);
    run = 1'b1;
    ticks(7);
    chk("R5 resume from zero short", min_elapsed, 1'b0);
    ticks(1);
    chk("R5 resume from zero reach", min_elapsed, 1'b1);
  endtask

  task automatic t_timeout_sticky;
    edge_code(2'd3);           // count 5, wrap after 1019 ticks
    ticks(1018);
    chk("R6 before wrap", timeout, 1'b0);
    chk("R6 elapsed at top", min_elapsed, 1'b1);
    ticks(1);
    chk("R6 wrap sets timeout", timeout, 1'b1);
    chk("R6 elapsed low after wrap", min_elapsed, 1'b0);
    edge_code(2'd0);
    chk("R7 edge keeps flag", timeout, 1'b1);
    run = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7 stop keeps flag", timeout, 1'b1);
    run = 1'b1;
    cyc(1'b0, 1'b0, 1'b1);
    chk("R7 clear strobe", timeout, 1'b0);
  endtask

  task automatic t_set_beats_clear;
    edge_code(2'd3);
    ticks(1018);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R8 set wins over clear", timeout, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8 later clear", timeout, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_min_per_code();
    t_edge_beats_tick();
    t_hold();
    t_stop();
    t_timeout_sticky();
    t_set_beats_clear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule